// File: doc/BRIEF.md
# Handshaked Output Latch Port

This block is a byte-wide output port that hands data from a host to a peripheral with a two-signal handshake. The host ends a write by raising its active-low write strobe. The byte present at that moment is stored, and an active-low "buffer full" flag drops to tell the peripheral that fresh data is waiting. The peripheral takes the byte by pulling its active-low acknowledge low. This releases the flag and opens the output drive for as long as the acknowledge stays low. When the acknowledge goes high again, an interrupt request toward the host is raised, provided the host has enabled it. The next host write begins with the strobe falling, and that edge withdraws the request.

The write strobe, its data and the acknowledge all arrive asynchronously. They pass through a parameterised synchronizer, and every set or clear action is driven by an edge found in the synchronized copy. The output is a data bus with a separate output-enable; while the enable is low the bus reads as zero. The interrupt-enable bit is loaded from a clock-synchronous strobe.

Top module: `ack_out_port`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, obf_n is 1, intr is 0, port_oe is 0, port_q is 0, the stored byte is 0 and the interrupt enable is 0.
- R2: A rising edge on wr_n stores the din value that was sampled with it and drives obf_n to 0. Both take effect on the SYNC_STAGES+1-th rising clock edge after the change.
- R3: A falling edge on ack_n drives obf_n to 1 with the same latency. If a wr_n rising edge is detected in the same cycle, obf_n goes to 0 instead.
- R4: port_oe becomes 1 on a detected ack_n falling edge and 0 on a detected ack_n rising edge. port_q equals the stored byte while port_oe is 1 and is 0 otherwise.
- R5: A detected ack_n rising edge sets intr to 1 when the interrupt enable is 1. When the enable is 0, intr is left unchanged.
- R6: A detected wr_n falling edge clears intr to 0, and this clear takes priority over a set in the same cycle.
- R7: When ie_wr is 1 at a rising clock edge, the interrupt enable takes the value of ie_din. The new value first governs the interrupt on the following edge.
- R8: The stored byte changes only on a detected wr_n rising edge. A second write before an acknowledge overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_n | input | 1 | Active-low host write strobe; the rising edge ends the write |
| din | input | DATA_W | Host write data, sampled together with wr_n |
| ie_wr | input | 1 | Synchronous load strobe for the interrupt enable |
| ie_din | input | 1 | Value loaded into the interrupt enable |
| ack_n | input | 1 | Active-low peripheral acknowledge |
| obf_n | output | 1 | Active-low buffer-full flag toward the peripheral |
| port_q | output | DATA_W | Port data, zero while not enabled |
| port_oe | output | 1 | Port output enable |
| intr | output | 1 | Interrupt request toward the host |

## Verification
Every result driven by wr_n or ack_n appears on the third rising clock edge after the input changes: two synchronizer stages plus the state register. An ie_wr load takes effect on the very next edge. The bench changes inputs only at falling clock edges. It keeps a three-deep history of what the design samples at each rising edge, updates its expected state from the entries two and three edges old, and compares all outputs at the next falling edge. Directed checks also confirm that obf_n is still high two edges after a write ends and falls on the third.

// File: rtl/ack_port_pkg.sv
package ack_port_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;

   function automatic edge_t find_edge(input logic cur, input logic prev);
      edge_t e;
      e.rise = cur & ~prev;
      e.fall = ~cur & prev;
      return e;
   endfunction

endpackage

// File: rtl/ack_port_rst_sync.sv
module ack_port_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_n_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("ack_port_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = chain[STAGES-1];
endmodule

// File: rtl/ack_port_sync.sv
module ack_port_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("ack_port_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_w
         $error("ack_port_sync: W must be at least 1");
      end

      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         logic [W-1:0] r;
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= RST_VAL;
               else        r <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= RST_VAL;
               else        r <= g_stage[g-1].r;
            end
         end
      end
   endgenerate

   assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/ack_port_ctrl.sv
module ack_port_ctrl
   import ack_port_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n_s,
   input  logic [DATA_W-1:0] din_s,
   input  logic              ack_n_s,
   input  logic              ie_wr,
   input  logic              ie_din,
   output logic              obf_n,
   output logic [DATA_W-1:0] port_q,
   output logic              port_oe,
   output logic              intr
);
   logic              wr_d, ack_d;
   logic [DATA_W-1:0] data_q;
   logic              obf_q, oe_q, ie_q, intr_q;
   edge_t             we, ae;
   logic              wr_rise, wr_fall, ack_rise, ack_fall;

   always_comb begin
      we       = find_edge(wr_n_s, wr_d);
      ae       = find_edge(ack_n_s, ack_d);
      wr_rise  = we.rise;
      wr_fall  = we.fall;
      ack_rise = ae.rise;
      ack_fall = ae.fall;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_d   <= 1'b1;
         ack_d  <= 1'b1;
         data_q <= '0;
         obf_q  <= 1'b1;
         oe_q   <= 1'b0;
         ie_q   <= 1'b0;
         intr_q <= 1'b0;
      end else begin
         wr_d  <= wr_n_s;
         ack_d <= ack_n_s;
         if (ie_wr) ie_q <= ie_din;
         if (wr_rise) begin
            obf_q  <= 1'b0;
            data_q <= din_s;
         end else if (ack_fall) begin
            obf_q <= 1'b1;
         end
         if (ack_fall)      oe_q <= 1'b1;
         else if (ack_rise) oe_q <= 1'b0;
         if (wr_fall)                intr_q <= 1'b0;
         else if (ack_rise && ie_q)  intr_q <= 1'b1;
      end
   end

   assign obf_n   = obf_q;
   assign port_oe = oe_q;
   assign port_q  = oe_q ? data_q : '0;
   assign intr    = intr_q;

   a_r2_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rise |=> !obf_n);
   a_r3_obf_release: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fall && !wr_rise) |=> obf_n);
   a_r4_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_fall && !ack_rise) |=> $stable(port_oe));
   a_r4_float_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !port_oe |-> (port_q == '0));
   a_r5_intr_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rise && ie_q && !wr_fall) |=> intr);
   a_r6_intr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fall |=> !intr);
   a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_rise |=> $stable(data_q));
endmodule

// File: rtl/ack_out_port.sv
module ack_out_port #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] din,
   input  logic              ie_wr,
   input  logic              ie_din,
   input  logic              ack_n,
   output logic              obf_n,
   output logic [DATA_W-1:0] port_q,
   output logic              port_oe,
   output logic              intr
);
   localparam int WR_W = DATA_W + 1;
   localparam logic [WR_W-1:0] WR_RST = {1'b1, {DATA_W{1'b0}}};

   logic              rst_n_i;
   logic [WR_W-1:0]   wr_bus_s;
   logic              ack_n_s;

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("ack_out_port: DATA_W must be at least 1");
      end
   endgenerate

   ack_port_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_i)
   );

   ack_port_sync #(.W(WR_W), .STAGES(SYNC_STAGES), .RST_VAL(WR_RST)) u_wr_sync (
      .clk(clk), .rst_n(rst_n_i), .d({wr_n, din}), .q(wr_bus_s)
   );

   ack_port_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
      .clk(clk), .rst_n(rst_n_i), .d(ack_n), .q(ack_n_s)
   );

   ack_port_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n_i),
      .wr_n_s(wr_bus_s[WR_W-1]), .din_s(wr_bus_s[DATA_W-1:0]),
      .ack_n_s(ack_n_s), .ie_wr(ie_wr), .ie_din(ie_din),
      .obf_n(obf_n), .port_q(port_q), .port_oe(port_oe), .intr(intr)
   );
endmodule

// File: tb/ack_out_port_tb.sv
module ack_out_port_tb;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_n = 1'b1, ack_n = 1'b1, ie_wr = 1'b0, ie_din = 1'b0;
   logic [DW-1:0] din = '0;
   logic          obf_n, port_oe, intr;
   logic [DW-1:0] port_q;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic          hw [4];
   logic          ha [4];
   logic [DW-1:0] hd [4];
   logic          m_obf, m_oe, m_ie, m_intr;
   logic [DW-1:0] m_data;

   always #4 clk = ~clk;

   ack_out_port #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .din(din), .ie_wr(ie_wr),
      .ie_din(ie_din), .ack_n(ack_n), .obf_n(obf_n), .port_q(port_q),
      .port_oe(port_oe), .intr(intr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] exp_port(input logic oe, input logic [DW-1:0] d);
      return oe ? d : '0;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin hw[i] = 1'b1; ha[i] = 1'b1; hd[i] = '0; end
      m_obf = 1'b1; m_oe = 1'b0; m_ie = 1'b0; m_intr = 1'b0; m_data = '0;
   endtask

   task automatic step();
      logic wr_r, wr_f, ack_r, ack_f, old_ie;
      @(posedge clk);
      for (int i = 3; i > 0; i--) begin hw[i] = hw[i-1]; ha[i] = ha[i-1]; hd[i] = hd[i-1]; end
      hw[0] = wr_n; ha[0] = ack_n; hd[0] = din;
      wr_r  = hw[2] & ~hw[3];  wr_f  = ~hw[2] & hw[3];
      ack_r = ha[2] & ~ha[3];  ack_f = ~ha[2] & ha[3];
      old_ie = m_ie;
      if (ie_wr) m_ie = ie_din;                          // R7
      if (wr_r) begin m_obf = 1'b0; m_data = hd[2]; end  // R2, R8
      else if (ack_f) m_obf = 1'b1;                      // R3
      if (ack_f) m_oe = 1'b1; else if (ack_r) m_oe = 1'b0;  // R4
      if (wr_f) m_intr = 1'b0;                           // R6
      else if (ack_r && old_ie) m_intr = 1'b1;           // R5
      @(negedge clk);
      chk("R2/R3 obf_n", obf_n, m_obf);
      chk("R4 port_oe", port_oe, m_oe);
      chk("R4/R8 port_q", port_q, exp_port(m_oe, m_data));
      chk("R5/R6 intr", intr, m_intr);
   endtask

   task automatic hold(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_n = 1'b1; ack_n = 1'b1; ie_wr = 1'b0; din = '0;
      model_reset();
      #1;
      chk("R1 obf_n in reset", obf_n, 1'b1);
      chk("R1 intr in reset", intr, 1'b0);
      chk("R1 port_oe in reset", port_oe, 1'b0);
      chk("R1 port_q in reset", port_q, 0);
      @(negedge clk);
      rst_n = 1'b1;
      hold(4);
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      model_reset();
      do_reset();

      // R1: enable is 0 after reset, so an acknowledge cycle raises no interrupt
      din = 8'hA5; wr_n = 1'b0; hold(3);
      wr_n = 1'b1; hold(2);
      chk("R2 latency obf_n still high", obf_n, 1'b1);
      hold(1);
      chk("R2 obf_n low after write", obf_n, 1'b0);
      chk("R4 port_q zero while not enabled", port_q, 0);
      ack_n = 1'b0; hold(3);
      chk("R3 obf_n released", obf_n, 1'b1);
      chk("R4 port_oe on", port_oe, 1'b1);
      chk("R2 port_q shows data", port_q, 8'hA5);
      ack_n = 1'b1; hold(3);
      chk("R1 intr with enable reset", intr, 1'b0);
      chk("R4 port_oe off", port_oe, 1'b0);

      // R7: set enable, then R5
      ie_wr = 1'b1; ie_din = 1'b1; step(); ie_wr = 1'b0;
      din = 8'h3C; wr_n = 1'b0; hold(3); wr_n = 1'b1; hold(3);
      din = 8'h5A; wr_n = 1'b0; hold(3); wr_n = 1'b1; hold(3); // R8 overwrite
      ack_n = 1'b0; hold(3);
      chk("R8 second write overwrites", port_q, 8'h5A);
      ack_n = 1'b1; hold(3);
      chk("R5 intr set on ack end", intr, 1'b1);
      wr_n = 1'b0; hold(3);
      chk("R6 intr cleared by write start", intr, 1'b0);
      wr_n = 1'b1; hold(3);

      // R7: disable, acknowledge must not raise intr
      ie_wr = 1'b1; ie_din = 1'b0; step(); ie_wr = 1'b0;
      ack_n = 1'b0; hold(3); ack_n = 1'b1; hold(3);
      chk("R7 disabled enable keeps intr low", intr, 1'b0);

      // Random phase
      ie_wr = 1'b1; ie_din = 1'b1; step(); ie_wr = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(5) == 0) wr_n = ~wr_n;
         if ($urandom_range(5) == 0) ack_n = ~ack_n;
         din = DW'($urandom);
         ie_wr = ($urandom_range(19) == 0);
         ie_din = $urandom_range(1);
         step();
         if (i == 2000) begin
            do_reset();
            chk("R1 intr after mid reset", intr, 1'b0);
         end
      end
      ie_wr = 1'b0;

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule